// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Late Write

This block is a single-port synchronous memory that lets a read, a write or a deselect start on every clock, with no idle cycle when the traffic switches direction. Every control and address input is registered on the rising edge. That happens only while the active-low clock enable is low. While the clock enable is high, the whole block freezes, including a write that is half done.

Reads are flow-through. Once a read command has been registered, the word at its address appears on `dataOut` during that same following cycle. The asynchronous active-low output enable decides whether `dataDrive` is raised.

Writes are late writes. The address and command are registered on one edge. The data and the per-byte write selects are taken on the next enabled edge. Captured data waits in a one-entry write buffer, and is forwarded to any read of the same address, so a read placed directly after a write sees the new bytes.

Three chip enables of mixed polarity allow several instances to share one bus. The bidirectional bus is modelled as `dataIn`, `dataOut` and a drive-enable.

Top module: `lateWriteSram`

## Requirements
- R1: Control, address, data and byte-select inputs take effect only at a rising edge where `clkEnN` is 0; address changes at any other time do not alter `dataOut`.
- R2: At an edge where `clkEnN` is 1, all state holds. This includes a write whose address is registered but whose data is not yet taken. That write takes its data at the next edge with `clkEnN` at 0.
- R3: An access starts at an enabled edge only when `ce1N`=0, `ce2`=1, `ce3N`=0 and `advLdN`=0. With `weN`=1 it is a read: during the next cycle `dataOut` holds the word stored at the registered address, and `dataDrive` is 1 while `outEnN` is 0.
- R4: `outEnN`=1 forces `dataDrive` to 0 with no clock edge needed, and `outEnN`=0 restores it within the same cycle.
- R5: An access with `weN`=0 is a write. Its address is registered at that edge, and `dataIn` and `byteWeN` are captured at the next enabled edge.
- R6: In the cycle after a write command, `dataDrive` is 0 whatever the level of `outEnN`.
- R7: `byteWeN[i]`=0 writes lane i, which is bits `i*LANE_W +: LANE_W`. `byteWeN[i]`=1 leaves that lane's stored contents unchanged.
- R8: An enabled edge with any chip enable inactive, or with `advLdN`=1, starts no access, and `dataDrive` is 0 in the following cycle.
- R9: A read of the address written by the immediately preceding write returns the newly captured lanes, merged with the old contents of the lanes that were not selected.
- R10: Reads and writes may alternate in any order on consecutive enabled edges, and every read returns the latest data written to its address.
- R11: Reset (`rstN`=0) cancels any registered read or write and holds `dataDrive` at 0. Contents already committed to the array survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low reset of the control state |
| clkEnN | input | 1 | Active-low clock qualifier |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| advLdN | input | 1 | Low loads a new address and starts an access |
| weN | input | 1 | Low selects write, high selects read |
| byteWeN | input | LANES | Active-low per-lane write selects, taken with the write data |
| outEnN | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| dataIn | input | LANES*LANE_W | Write data, taken one enabled edge after the write command |
| dataOut | output | LANES*LANE_W | Read data |
| dataDrive | output | 1 | High when the block drives the data bus |

## Verification
The hardest case to reach from the ports is a write whose data phase is stalled by the clock enable while the address bus keeps changing, followed at once by a read of the same address. In that case the data must come from the write buffer and not from the array. The bench reaches it with a directed sequence: a write command, three cycles with `clkEnN` high and junk on `dataIn`, then the real data alongside a read of the same address. A partial byte mask is used so that the merge of old and new lanes is visible. A random phase then confines addresses to eight words and mixes stalls, deselects, byte masks and output-enable toggles, so that write-then-read collisions happen often.

// File: rtl/lateWriteSramPkg.sv
package lateWriteSramPkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic step;   // an enabled clock edge is coming
    logic capWr;  // the data phase of a write happens at that edge
    logic rdOn;   // a read is active in this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/lateWriteSramCtrl.sv
module lateWriteSramCtrl
  import lateWriteSramPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              advLdN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] opAddr,
  output ctrlStrobe_t       strobe
);

  logic accessSel;
  logic rdActive;
  logic wrPending;

  // All three chip enables active plus a load request.
  assign accessSel = ~ce1N & ce2 & ~ce3N & ~advLdN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActive  <= 1'b0;
      wrPending <= 1'b0;
      opAddr    <= '0;
    end else if (!clkEnN) begin
      rdActive  <= accessSel & weN;
      wrPending <= accessSel & ~weN;
      if (accessSel) begin
        opAddr <= addr;
      end
    end
  end

  always_comb begin
    strobe.step  = ~clkEnN;
    strobe.capWr = wrPending & ~clkEnN;
    strobe.rdOn  = rdActive;
  end

endmodule

// File: rtl/lateWriteSramData.sv
module lateWriteSramData
  import lateWriteSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [ADDR_W-1:0]       opAddr,
  input  logic [LANES-1:0]        byteWeN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] readWord
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] memArray [DEPTH];

  // One-entry buffer holding captured write data until the next enabled edge.
  logic              bufValid;
  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;
  logic [LANES-1:0]  bufMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufAddr  <= '0;
      bufData  <= '0;
      bufMask  <= '0;
    end else if (strobe.step) begin
      bufValid <= strobe.capWr;
      if (strobe.capWr) begin
        bufAddr <= opAddr;
        bufData <= dataIn;
        bufMask <= ~byteWeN;
      end
    end
  end

  // Commit the buffered lanes to the array; the array itself has no reset.
  always_ff @(posedge clk) begin
    if (strobe.step && bufValid) begin
      for (int lane = 0; lane < LANES; lane++) begin
        if (bufMask[lane]) begin
          memArray[bufAddr][lane*LANE_W +: LANE_W] <= bufData[lane*LANE_W +: LANE_W];
        end
      end
    end
  end

  logic [DATA_W-1:0] arrayWord;
  logic              addrHit;

  assign arrayWord = memArray[opAddr];
  assign addrHit   = bufValid && (bufAddr == opAddr);

  // Lane-wise forwarding from the buffer, so a read after a write sees new bytes.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign readWord[g*LANE_W +: LANE_W] = (addrHit && bufMask[g])
                                          ? bufData[g*LANE_W +: LANE_W]
                                          : arrayWord[g*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/lateWriteSram.sv
module lateWriteSram
  import lateWriteSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    advLdN,
  input  logic                    weN,
  input  logic [LANES-1:0]        byteWeN,
  input  logic                    outEnN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] opAddr;

  lateWriteSramCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .clkEnN (clkEnN),
    .ce1N   (ce1N),
    .ce2    (ce2),
    .ce3N   (ce3N),
    .advLdN (advLdN),
    .weN    (weN),
    .addr   (addr),
    .opAddr (opAddr),
    .strobe (strobe)
  );

  lateWriteSramData #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opAddr   (opAddr),
    .byteWeN  (byteWeN),
    .dataIn   (dataIn),
    .readWord (dataOut)
  );

  // The output enable gates the drive combinationally.
  assign dataDrive = strobe.rdOn & ~outEnN;

endmodule

// File: rtl/lateWriteSramChk.sv
module lateWriteSramChk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              advLdN,
  input logic              weN,
  input logic              outEnN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataDrive
);

  logic startAcc;
  assign startAcc = !clkEnN && !ce1N && ce2 && !ce3N && !advLdN;

  // R1, R2: a stalled edge changes nothing visible on the read path
  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(dataOut));

  // R4
  assert_oe_gates_R4: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataDrive);

  // R3
  assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startAcc && weN) |=> (dataDrive || outEnN));

  // R6
  assert_write_no_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startAcc && !weN) |=> !dataDrive);

  // R8
  assert_deselect_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && (ce1N || !ce2 || ce3N || advLdN)) |=> !dataDrive);

  // R11
  always_comb begin
    if (!rstN) begin
      assert_reset_quiet_R11: assert (!dataDrive);
    end
  end

endmodule

bind lateWriteSram lateWriteSramChk #(.DATA_W(LANES*LANE_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clkEnN    (clkEnN),
  .ce1N      (ce1N),
  .ce2       (ce2),
  .ce3N      (ce3N),
  .advLdN    (advLdN),
  .weN       (weN),
  .outEnN    (outEnN),
  .dataOut   (dataOut),
  .dataDrive (dataDrive)
);

// File: tb/test_lateWriteSram.sv
`timescale 1ns/1ps
module test_lateWriteSram;

  localparam int AW = 6;
  localparam int NL = 2;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clkEnN = 1'b0;
  logic          ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1, advLdN = 1'b1, weN = 1'b1;
  logic [NL-1:0] byteWeN = '1;
  logic          outEnN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataDrive;

  int    testsRun = 0;
  int    testsFailed = 0;
  string tag = "R11";
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  lateWriteSram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_lateWriteSram (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advLdN(advLdN), .weN(weN), .byteWeN(byteWeN), .outEnN(outEnN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  // Behavioural reference: writes land at their data edge, reads see the latest value.
  logic [DW-1:0] mMem [NW];
  bit            mKnown [NW];
  bit            mRd = 0, mWr = 0;
  int            mAddr = 0;

  initial for (int i = 0; i < NW; i++) mKnown[i] = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mRd = 0;
      mWr = 0;
    end else if (!clkEnN) begin
      bit acc;
      if (mWr) begin
        for (int l = 0; l < NL; l++)
          if (!byteWeN[l]) mMem[mAddr][l*LW +: LW] = dataIn[l*LW +: LW];
        mKnown[mAddr] = 1;
      end
      acc = !ce1N && ce2 && !ce3N && !advLdN;
      mRd = acc && weN;
      mWr = acc && !weN;
      if (acc) mAddr = int'(addr);
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare at the falling edge, then hand control back so the caller drives inputs.
  task automatic tick();
    bit expDrive;
    @(negedge clk);
    expDrive = mRd && !outEnN && rstN;
    check(dataDrive == expDrive, tag, DW'(dataDrive), DW'(expDrive));
    if (expDrive && mKnown[mAddr])
      check(dataOut == mMem[mAddr], tag, dataOut, mMem[mAddr]);
  endtask

  task automatic selectOn();
    ce1N = 0; ce2 = 1; ce3N = 0; advLdN = 0;
  endtask

  task automatic opRead(input int a);
    tick(); clkEnN = 0; selectOn(); weN = 1; addr = AW'(a);
  endtask

  task automatic opWrite(input int a);
    tick(); clkEnN = 0; selectOn(); weN = 0; addr = AW'(a);
  endtask

  task automatic opIdle();
    tick(); clkEnN = 0; ce1N = 1; advLdN = 0; weN = 1;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 1237 + 91);
  endfunction

  initial begin
    // R11: reset quiet state
    outEnN = 0;
    repeat (3) tick();
    check(dataDrive == 0, "R11", DW'(dataDrive), 0);
    rstN = 1;

    // R5: back-to-back full writes, data one edge behind its address
    tag = "R5";
    byteWeN = '0;
    for (int a = 0; a < NW; a++) begin
      opWrite(a);
      if (a > 0) dataIn = pat(a - 1);
    end
    opIdle(); dataIn = pat(NW - 1);
    opIdle();

    // R3: read every word back with the output enabled
    tag = "R3";
    for (int a = 0; a < NW; a++) opRead(a);
    opRead(7);
    tick();
    check(dataDrive == 1 && dataOut == pat(7), "R3", dataOut, pat(7));

    // R4: the output enable acts without a clock edge
    #1 outEnN = 1; #1;
    check(dataDrive == 0, "R4", DW'(dataDrive), 0);
    outEnN = 0; #1;
    check(dataDrive == 1, "R4", DW'(dataDrive), 1);
    tag = "R4";
    clkEnN = 1;
    tick(); outEnN = 1;
    tick(); outEnN = 0;

    // R8: each chip enable and the load input on its own stops the access
    tag = "R8";
    opRead(3); ce1N = 1;
    opRead(3); ce2 = 0;
    opRead(3); ce3N = 1;
    opRead(3); advLdN = 1;
    opRead(3);
    tick();
    check(dataDrive == 1, "R8", DW'(dataDrive), 1);
    clkEnN = 0; ce2 = 0;
    tick();
    check(dataDrive == 0, "R8", DW'(dataDrive), 0);

    // R7 and R6: partial byte writes with the output enable low
    tag = "R7";
    opWrite(5); outEnN = 0;
    tick(); check(dataDrive == 0, "R6", DW'(dataDrive), 0);
    clkEnN = 0; ce1N = 1; byteWeN = 2'b10; dataIn = 18'h3_ffff;
    opRead(5); byteWeN = '1;
    tick();
    check(dataOut == {pat(5)[DW-1:LW], 9'h1ff}, "R7", dataOut, {pat(5)[DW-1:LW], 9'h1ff});
    clkEnN = 0; ce1N = 1;

    // R9: a read right after a write to the same address is forwarded
    tag = "R9";
    opWrite(9);
    opRead(9); byteWeN = 2'b01; dataIn = 18'h2_a955;
    tick();
    check(dataOut == {9'h154, pat(9)[LW-1:0]}, "R9", dataOut, {9'h154, pat(9)[LW-1:0]});
    clkEnN = 0; ce1N = 1; byteWeN = '1;

    // R2: the data phase waits out a stall while the inputs wander
    tag = "R2";
    opWrite(3);
    for (int s = 0; s < 3; s++) begin
      tick(); clkEnN = 1; addr = AW'(s + 20); dataIn = 18'h0_0bad; byteWeN = '0; weN = 1;
    end
    opRead(3); byteWeN = '0; dataIn = 18'h1_2345;
    tick();
    check(dataOut == 18'h1_2345, "R2", dataOut, 18'h1_2345);
    clkEnN = 1; addr = 6'd40;
    tick();
    check(dataOut == 18'h1_2345, "R1", dataOut, 18'h1_2345);
    clkEnN = 0; byteWeN = '1; ce1N = 1;

    // R10: random mix confined to a few words
    tag = "R10";
    for (int n = 0; n < 2000; n++) begin
      tick();
      clkEnN  = ($urandom_range(0, 5) == 0);
      ce1N    = ($urandom_range(0, 9) == 0);
      ce2     = ($urandom_range(0, 9) != 0);
      ce3N    = ($urandom_range(0, 9) == 0);
      advLdN  = ($urandom_range(0, 9) == 0);
      weN     = $urandom_range(0, 1);
      outEnN  = ($urandom_range(0, 7) == 0);
      addr    = AW'($urandom_range(0, 7));
      byteWeN = NL'($urandom);
      dataIn  = DW'($urandom);
    end

    // R11: reset mid-session after traffic settles; array contents remain
    tag = "R11";
    opIdle(); opIdle(); opIdle();
    rstN = 0;
    opRead(2);
    tick();
    check(dataDrive == 0, "R11", DW'(dataDrive), 0);
    rstN = 1;
    opRead(12);
    opRead(40);
    tick();
    check(dataOut == pat(40), "R11", dataOut, pat(40));
    tick();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule